// File: doc/BRIEF.md
# Dual Addressable Bit Latch

This block stores two banks of four bits each, called bank a and bank b. The banks share one 2-bit address, an active-low enable and an active-low clear. Each bank has its own 1-bit data input. All four stored bits of each bank are driven out in parallel. The levels of enable and clear pick one of four modes for both banks at once:

| en_n | clr_n | Mode |
|------|-------|------|
| 0 | 1 | addressable write |
| 1 | 1 | hold |
| 0 | 0 | demultiplex |
| 1 | 0 | clear |

Every stored bit is a flip-flop that updates only on the rising clock edge. The mode decode and the bit selection are combinational.

Use it as a serial-to-parallel loader: set an address while in hold, drop the enable for one or more cycles to write, then raise it again. The address must not move while writes are enabled, because a real latch could catch the wrong bit during the change. A sticky flag, `addr_err`, records any such address change so the integration can see the protocol violation. Only reset clears the flag.

Top module: `dual_addr_latch`

## Requirements
- R1: While rst_n is low at a rising edge, every stored bit of both banks and addr_err become 0. They read 0 at the first output sample after that edge.
- R2: In clear mode (en_n=1, clr_n=0), all eight bits go to 0 at the next rising edge, whatever the values on addr, din_a and din_b.
- R3: In addressable write mode (en_n=0, clr_n=1), bit k of each bank takes its own data input at the next edge, where k is the unsigned value of addr (addr[0] is the least significant bit, so addr=0 selects bit 0 and addr=3 selects bit 3). The other three bits of each bank keep their values.
- R4: In demultiplex mode (en_n=0, clr_n=0), the addressed bit of each bank takes that bank's data input at the next edge, and the other three bits of that bank go to 0.
- R5: In hold mode (en_n=1, clr_n=1), all eight bits keep their values. Changes on din_a, din_b and addr have no effect.
- R6: Both banks always act in the same mode and on the same address, and each bank takes only its own data input. For example, din_a=1 with din_b=0 writes 1 into bank a and 0 into bank b.
- R7: addr_err goes to 1 at an edge where the block is in write mode, the block was also in write mode at the previous edge, and addr differs from its value at that previous edge. Repeated write cycles on an unchanged address leave the flag at 0.
- R8: An address change does not set addr_err when either of the two edges involved is in hold, clear or demultiplex mode.
- R9: Once addr_err is 1, it stays 1 in every mode until rst_n is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Bit select shared by both banks |
| en_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low clear |
| din_a | input | 1 | Data input for bank a |
| din_b | input | 1 | Data input for bank b |
| q_a | output | 4 | Stored bits of bank a |
| q_b | output | 4 | Stored bits of bank b |
| addr_err | output | 1 | Sticky flag: address changed while writes were enabled |

## Verification
Two functions can act at the same edge: a write to the addressed bit, and the raising of addr_err. Both happen when the address moves between two consecutive write cycles. The bench provokes this case by stepping the address from one write cycle directly to the next. It then checks two things at that edge: the newly addressed bit in both banks holds its data value, and the flag rises. Later clear-mode and hold cycles confirm that the flag stays high. Address changes that pass through hold or demultiplex cycles must leave the flag low.

// File: rtl/dal_pkg.sv
// Shared types for the dual addressable bit latch.
// Assumes a 2-bit enable/clear mode field decoded in one place.
package dal_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } dal_mode_e;
endpackage

// File: rtl/dal_mode_decode.sv
// Turns the active-low enable/clear pair into a mode value.
// Purely combinational; both banks share the result.
module dal_mode_decode
    import dal_pkg::*;
(
    input  logic      en_n,
    input  logic      clr_n,
    output dal_mode_e mode
);
    // Select the mode from the two control levels
    always_comb begin
        unique case ({en_n, clr_n})
            2'b01:   mode = MODE_WRITE;
            2'b11:   mode = MODE_HOLD;
            2'b00:   mode = MODE_DEMUX;
            default: mode = MODE_CLEAR;
        endcase
    end
endmodule

// File: rtl/dal_bank.sv
// One bank of BITS stored bits with addressed entry.
// Assumes the mode and address are stable for the cycle; updates on the rising edge only.
module dal_bank
    import dal_pkg::*;
#(
    parameter int BITS   = 4,
    parameter int ADDR_W = $clog2(BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dal_mode_e         mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic [BITS-1:0]   q
);
    logic [BITS-1:0] nxt;

    for (genvar i = 0; i < BITS; i++) begin : g_bit
        logic hit;
        assign hit = (addr == ADDR_W'(i));

        // Next value of bit i for the current mode
        always_comb begin
            unique case (mode)
                MODE_CLEAR: nxt[i] = 1'b0;
                MODE_DEMUX: nxt[i] = hit ? din : 1'b0;
                MODE_WRITE: nxt[i] = hit ? din : q[i];
                default:    nxt[i] = q[i];
            endcase
        end
    end

    // Store the bank on the rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/dal_addr_guard.sv
// Flags an address change across two back-to-back write-mode edges.
// The flag is sticky until the synchronous reset.
module dal_addr_guard
    import dal_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dal_mode_e         mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              err
);
    logic              was_write;
    logic [ADDR_W-1:0] last_addr;
    logic              moved;

    // Detect a move between this write edge and the previous one
    always_comb moved = (mode == MODE_WRITE) && was_write && (addr != last_addr);

    // Track the previous edge and latch the flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            was_write <= 1'b0;
            last_addr <= '0;
            err       <= 1'b0;
        end else begin
            was_write <= (mode == MODE_WRITE);
            last_addr <= addr;
            if (moved) err <= 1'b1;
        end
    end
endmodule

// File: rtl/dual_addr_latch.sv
// Top level: two banks with a shared address, enable and clear, plus the address guard.
// Assumes one clock domain; every stored bit changes only on the rising edge.
module dual_addr_latch
    import dal_pkg::*;
#(
    parameter int BITS   = 4,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_n,
    input  logic              clr_n,
    input  logic              din_a,
    input  logic              din_b,
    output logic [BITS-1:0]   q_a,
    output logic [BITS-1:0]   q_b,
    output logic              addr_err
);
    localparam int BANKS = 2;

    dal_mode_e         mode;
    logic [BANKS-1:0]  din_v;
    logic [BITS-1:0]   q_v [BANKS];

    dal_mode_decode u_dec (
        .en_n  (en_n),
        .clr_n (clr_n),
        .mode  (mode)
    );

    assign din_v = {din_b, din_a};

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        dal_bank #(.BITS(BITS), .ADDR_W(ADDR_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode),
            .addr  (addr),
            .din   (din_v[b]),
            .q     (q_v[b])
        );
    end

    assign q_a = q_v[0];
    assign q_b = q_v[1];

    dal_addr_guard #(.ADDR_W(ADDR_W)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .addr  (addr),
        .err   (addr_err)
    );
endmodule

// File: rtl/dal_checker.sv
// Port-level properties of the dual addressable bit latch; attached by bind.
module dal_checker #(
    parameter int BITS   = 4,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              en_n,
    input logic              clr_n,
    input logic [BITS-1:0]   q_a,
    input logic [BITS-1:0]   q_b,
    input logic              addr_err
);
    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n && !clr_n) |=> (q_a == '0 && q_b == '0));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n && clr_n) |=> ($stable(q_a) && $stable(q_b)));

    // R4
    demux_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !clr_n) |=> ($onehot0(q_a) && $onehot0(q_b)));

    // R3
    write_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && clr_n) |=>
            (((q_a ^ $past(q_a)) & ~(BITS'(1) << $past(addr))) == '0) &&
            (((q_b ^ $past(q_b)) & ~(BITS'(1) << $past(addr))) == '0));

    // R8
    err_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_err && !(!en_n && clr_n)) |=> !addr_err);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> addr_err);
endmodule

bind dual_addr_latch dal_checker #(.BITS(BITS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .en_n     (en_n),
    .clr_n    (clr_n),
    .q_a      (q_a),
    .q_b      (q_b),
    .addr_err (addr_err)
);

// File: tb/dual_addr_latch_bench.sv
// Scoreboard bench: the driver computes expected outputs, the monitor compares them after each edge.
module dual_addr_latch_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic       din_a = 1'b0;
    logic       din_b = 1'b0;
    logic [3:0] q_a, q_b;
    logic       addr_err;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    typedef struct {
        logic [3:0] qa;
        logic [3:0] qb;
        logic       err;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];

    logic [3:0] m_a = '0, m_b = '0;
    logic       m_err = 1'b0, m_pw = 1'b0;
    logic [1:0] m_pa = '0;

    dual_addr_latch u_dual_addr_latch (
        .clk(clk), .rst_n(rst_n), .addr(addr), .en_n(en_n), .clr_n(clr_n),
        .din_a(din_a), .din_b(din_b), .q_a(q_a), .q_b(q_b), .addr_err(addr_err)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [8:0] act, input logic [8:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Drive one cycle of inputs at the falling edge and queue the expected result
    task automatic drive(input logic e, input logic c, input logic [1:0] a,
                         input logic da, input logic db, input string tag);
        @(negedge clk);
        en_n = e; clr_n = c; addr = a; din_a = da; din_b = db;
        case ({e, c})
            2'b10: begin m_a = '0; m_b = '0; end
            2'b00: begin m_a = '0; m_b = '0; m_a[a] = da; m_b[a] = db; end
            2'b01: begin m_a[a] = da; m_b[a] = db; end
            default: ;
        endcase
        if ({e, c} == 2'b01 && m_pw && a != m_pa) m_err = 1'b1;
        m_pw = ({e, c} == 2'b01);
        m_pa = a;
        exp_q.push_back('{m_a, m_b, m_err});
        tag_q.push_back(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; en_n = 1'b1; clr_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 outputs after reset edges
        check({q_a, q_b, addr_err} == 9'd0, "R1", {q_a, q_b, addr_err}, 9'd0);
        m_a = '0; m_b = '0; m_err = 1'b0; m_pw = 1'b0; m_pa = '0;
        rst_n = 1'b1;
    endtask

    // Monitor: compare after every rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t  x;
                string t;
                x = exp_q.pop_front();
                t = tag_q.pop_front();
                check({q_a, q_b, addr_err} == {x.qa, x.qb, x.err}, t,
                      {q_a, q_b, addr_err}, {x.qa, x.qb, x.err});
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected <5000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R3 R6 writes, address moved only in hold (R8)
        drive(1, 1, 2'd0, 0, 0, "R5");
        drive(0, 1, 2'd0, 1, 0, "R3");
        drive(0, 1, 2'd0, 1, 0, "R7");
        drive(1, 1, 2'd2, 0, 1, "R8");
        drive(0, 1, 2'd2, 1, 1, "R6");
        drive(1, 1, 2'd3, 0, 0, "R8");
        drive(0, 1, 2'd3, 0, 1, "R3");
        drive(1, 1, 2'd1, 1, 1, "R5");
        drive(1, 1, 2'd0, 0, 1, "R5");
        drive(0, 1, 2'd0, 0, 1, "R3");
        // R4 demultiplex, address moves freely (R8)
        drive(0, 0, 2'd1, 1, 0, "R4");
        drive(0, 0, 2'd3, 1, 1, "R4");
        drive(0, 0, 2'd2, 0, 1, "R8");
        // R2 clear ignores data and address
        drive(1, 0, 2'd1, 1, 1, "R2");
        drive(1, 1, 2'd1, 1, 1, "R5");
        // R7 move between back-to-back writes; write lands the same edge
        drive(0, 1, 2'd1, 1, 0, "R3");
        drive(0, 1, 2'd2, 1, 1, "R7");
        drive(1, 0, 2'd0, 0, 0, "R9");
        drive(1, 1, 2'd3, 1, 1, "R9");
        drive(0, 0, 2'd3, 1, 1, "R9");
        repeat (3) @(negedge clk);
        // R1 reset clears the sticky flag
        do_reset();
        drive(1, 1, 2'd0, 0, 0, "R1");
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule